// File: doc/BRIEF.md
# Channel Address Interleave Remover

This block turns a system physical address into the address one memory channel sees. A range decoder further up selects a memory controller and a channel. This block takes that pair together with the system address. It then searches a small table of programmable address windows that belongs to the selected controller. From the window that matches it subtracts the offset for that channel and that window. Last, it removes the two stacked interleaves, socket and channel, by dividing each way count out of the address at the bit position picked for that level.

A window is described by two 32-bit words, a base word and a ways word. Each controller holds `N_ENTRY` windows. A third 32-bit word holds the offset, one for every window and every channel. All words are loaded through a simple write port, and that port accepts writes only while no decode is in progress. Requests come in on a valid/ready handshake. Results leave on a second valid/ready handshake and carry the channel address, the socket way count, the channel way count and a miss flag.

The channel level may be 3-way. A 3-way level is removed with a serial restoring divider. One-way, 2-way, 4-way and 8-way levels are removed with a shift. The two levels are removed in a fixed order except in one case: when the channel level is 3-way and the socket interleave bit sits above the channel interleave bit, the order reverses and the restored low bits come from a different source.

Top module: `chan_addr_unilv`

## Requirements
- R1: Windows are tested in index order starting at 0, and the first one whose base ≤ address ≤ limit is used. The base is base-word bits 31:12 shifted up to address bit 26. The limit is ways-word bits 31:12 shifted up to address bit 26, with address bits 25:0 all set to one.
- R2: When no window matches, the result has `out_miss`=1, a channel address of 0, and both way counts equal to 1.
- R3: The socket way count is 1 shifted left by ways-word bits 11:10, giving 1, 2, 4 or 8. The channel way count is ways-word bits 9:8 plus one, giving 1 to 4.
- R4: Base-word bits 5:4 hold the socket granularity code and bits 7:6 hold the channel granularity code. Code 0 selects interleave bit 6, code 1 selects bit 8, code 2 selects bit 12 and code 3 selects bit 30.
- R5: Before any interleave is removed, offset-word bits 23:4, shifted up to address bit 26, are subtracted from the address modulo 2^ADDR_W. The offset word used is the one for the request's channel and the matched window.
- R6: Removing one level works as follows. Shift the value right by the granularity bit. Divide by the way count. Shift back left by the same amount. OR in the bits below the granularity bit taken from a low-bits source. If the channel way count is 3 and the socket bit is above the channel bit, the channel level is removed first and the socket level second, and each level takes its low bits from its own input value.
- R7: In all other cases the socket level is removed first and the channel level second, and both levels take their low bits from the original system address.
- R8: `in_ready` is high only when the block is idle. It drops in the cycle after a request is accepted. A result is held unchanged on the outputs until `out_ready` accepts it.
- R9: A configuration write issued while a decode is in progress, from acceptance until its result is taken, changes no stored word.
- R10: After reset every stored word is zero, `in_ready` is 1 and `out_valid` is 0. So window 0 then covers addresses 0 to 2^26−1, with 1 way at each level and no offset.
- R11: `cfg_kind` selects which word is written: 0 writes the base word of (controller, window), 1 writes the ways word of (controller, window), 2 writes the offset word of (controller, channel, window), and 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Word selector for the write (R11) |
| cfg_ctrl | input | CTRL_W | Controller index for the write |
| cfg_chan | input | CHAN_W | Channel index for an offset write |
| cfg_entry | input | ENT_W | Window index for the write |
| cfg_data | input | 32 | Word written |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block idle, request may be accepted |
| in_addr | input | ADDR_W | System address |
| in_ctrl | input | CTRL_W | Controller index from the range decoder |
| in_chan | input | CHAN_W | Channel index from the range decoder |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result accepted |
| out_chan_addr | output | ADDR_W | Address within the channel |
| out_skt_ways | output | 4 | Socket way count |
| out_chan_ways | output | 3 | Channel way count |
| out_miss | output | 1 | No window matched |

## Verification
The assertions assume that every request names a controller below `N_CTRL` and a channel below `N_CHAN`. They also assume that `out_ready` is eventually raised, because the latency bound is counted only while the block is working and not while it waits on the output side. The stimulus keeps the controller at 0 or 1 and the channel at 0 to 2. Random window sets are built to be contiguous, with a gap that forces misses. Directed cases cover a write during a decode, holding the output back, and both removal orders with a 3-way channel level.

// File: rtl/cau_pkg.sv
package cau_pkg;

   // Write selector for the configuration port
   typedef enum logic [1:0] {
      CFG_BASE = 2'd0,
      CFG_WAYS = 2'd1,
      CFG_OFS  = 2'd2,
      CFG_NONE = 2'd3
   } cfg_kind_e;

   // Address bit at which window base, limit and offset fields sit
   localparam int unsigned FIELD_LSB = 26;
   localparam int unsigned FIELD_W   = 20;
   localparam int unsigned MIN_ADDR_W = FIELD_LSB + FIELD_W;

   // Interleave bit selected by a 2-bit granularity code
   function automatic int unsigned gran_bit(input logic [1:0] code);
      case (code)
         2'd0:    return 6;
         2'd1:    return 8;
         2'd2:    return 12;
         default: return 30;
      endcase
   endfunction

endpackage

// File: rtl/cau_cfg_store.sv
module cau_cfg_store
   import cau_pkg::*;
#(
   parameter int unsigned N_CTRL  = 2,
   parameter int unsigned N_CHAN  = 3,
   parameter int unsigned N_ENTRY = 8,
   parameter int unsigned CTRL_W  = 1,
   parameter int unsigned CHAN_W  = 2,
   parameter int unsigned ENT_W   = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_kind,
   input  logic [CTRL_W-1:0] wr_ctrl,
   input  logic [CHAN_W-1:0] wr_chan,
   input  logic [ENT_W-1:0]  wr_ent,
   input  logic [31:0]       wr_data,
   input  logic [CTRL_W-1:0] rd_ctrl,
   input  logic [CHAN_W-1:0] rd_chan,
   input  logic [ENT_W-1:0]  rd_ent,
   output logic [31:0]       rd_base,
   output logic [31:0]       rd_ways,
   output logic [31:0]       rd_ofs
);

   logic [31:0] base_by_ctrl [N_CTRL];
   logic [31:0] ways_by_ctrl [N_CTRL];
   logic [31:0] ofs_by_cc    [N_CTRL][N_CHAN];

   logic ent_wr_ok;
   assign ent_wr_ok = (32'(wr_ent) < N_ENTRY);

   for (genvar gc = 0; gc < N_CTRL; gc++) begin : g_ctrl
      logic [31:0] base_q [N_ENTRY];
      logic [31:0] ways_q [N_ENTRY];
      logic        sel_ctrl;

      assign sel_ctrl = wr_en && ent_wr_ok && (wr_ctrl == CTRL_W'(gc));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < int'(N_ENTRY); i++) begin
               base_q[i] <= '0;
               ways_q[i] <= '0;
            end
         end else if (sel_ctrl) begin
            if (wr_kind == CFG_BASE) base_q[wr_ent] <= wr_data;
            if (wr_kind == CFG_WAYS) ways_q[wr_ent] <= wr_data;
         end
      end

      assign base_by_ctrl[gc] = base_q[rd_ent];
      assign ways_by_ctrl[gc] = ways_q[rd_ent];

      for (genvar gh = 0; gh < N_CHAN; gh++) begin : g_chan
         logic [31:0] ofs_q [N_ENTRY];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(N_ENTRY); i++) ofs_q[i] <= '0;
            end else if (sel_ctrl && (wr_kind == CFG_OFS) &&
                         (wr_chan == CHAN_W'(gh))) begin
               ofs_q[wr_ent] <= wr_data;
            end
         end

         assign ofs_by_cc[gc][gh] = ofs_q[rd_ent];
      end
   end

   logic rd_ok;
   assign rd_ok = (32'(rd_ctrl) < N_CTRL) && (32'(rd_ent) < N_ENTRY);

   always_comb begin
      rd_base = '0;
      rd_ways = '0;
      rd_ofs  = '0;
      if (rd_ok) begin
         rd_base = base_by_ctrl[rd_ctrl];
         rd_ways = ways_by_ctrl[rd_ctrl];
         if (32'(rd_chan) < N_CHAN) rd_ofs = ofs_by_cc[rd_ctrl][rd_chan];
      end
   end

endmodule

// File: rtl/cau_div_restore.sv
module cau_div_restore #(
   parameter int unsigned NW = 46,
   parameter int unsigned DW = 2
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [NW-1:0] num,
   input  logic [DW-1:0] den,
   output logic          done,
   output logic [NW-1:0] quo
);

   localparam int unsigned CW = $clog2(NW + 1);

   logic          busy;
   logic [CW-1:0] left;
   logic [DW-1:0] rem;
   logic [DW-1:0] den_q;
   logic [NW-1:0] work;
   logic [DW:0]   trial;
   logic [DW:0]   rem_nx;
   logic          ge;

   // One quotient bit per cycle, most significant first
   always_comb begin
      trial  = {rem, work[NW-1]};
      ge     = (trial >= {1'b0, den_q});
      rem_nx = ge ? (trial - {1'b0, den_q}) : trial;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         left  <= '0;
         rem   <= '0;
         den_q <= '0;
         work  <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy  <= 1'b1;
            left  <= CW'(NW);
            rem   <= '0;
            den_q <= den;
            work  <= num;
         end else if (busy) begin
            rem  <= rem_nx[DW-1:0];
            work <= {work[NW-2:0], ge};
            left <= left - 1'b1;
            if (left == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign quo = work;

endmodule

// File: rtl/cau_level_strip.sv
module cau_level_strip
   import cau_pkg::*;
#(
   parameter int unsigned ADDR_W = 46
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] val,
   input  logic [ADDR_W-1:0] lo,
   input  logic [1:0]        gcode,
   input  logic [3:0]        ways,
   output logic              done,
   output logic [ADDR_W-1:0] res
);

   function automatic logic [ADDR_W-1:0] low_mask(input logic [1:0] code);
      return (ADDR_W'(1) << gran_bit(code)) - ADDR_W'(1);
   endfunction

   logic [ADDR_W-1:0] shifted;
   logic [1:0]        k;
   logic              is3;
   logic              div_done;
   logic [ADDR_W-1:0] quo;
   logic [1:0]        g_q;
   logic [ADDR_W-1:0] lo_q;

   assign shifted = val >> gran_bit(gcode);
   assign is3     = (ways == 4'd3);

   // Power-of-two way counts become a right shift
   always_comb begin
      case (ways)
         4'd2:    k = 2'd1;
         4'd4:    k = 2'd2;
         4'd8:    k = 2'd3;
         default: k = 2'd0;
      endcase
   end

   cau_div_restore #(
      .NW (ADDR_W),
      .DW (2)
   ) u_div3 (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start && is3),
      .num   (shifted),
      .den   (2'd3),
      .done  (div_done),
      .quo   (quo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0;
         res  <= '0;
         g_q  <= '0;
         lo_q <= '0;
      end else begin
         done <= 1'b0;
         if (start && !is3) begin
            res  <= ((shifted >> k) << gran_bit(gcode)) | (lo & low_mask(gcode));
            done <= 1'b1;
         end
         if (start && is3) begin
            g_q  <= gcode;
            lo_q <= lo;
         end
         if (div_done) begin
            res  <= (quo << gran_bit(g_q)) | (lo_q & low_mask(g_q));
            done <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/chan_addr_unilv.sv
module chan_addr_unilv
   import cau_pkg::*;
#(
   parameter int unsigned ADDR_W  = 46,
   parameter int unsigned N_CTRL  = 2,
   parameter int unsigned N_CHAN  = 3,
   parameter int unsigned N_ENTRY = 8,
   localparam int unsigned CTRL_W = (N_CTRL > 1) ? $clog2(N_CTRL) : 1,
   localparam int unsigned CHAN_W = (N_CHAN > 1) ? $clog2(N_CHAN) : 1,
   localparam int unsigned ENT_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_kind,
   input  logic [CTRL_W-1:0] cfg_ctrl,
   input  logic [CHAN_W-1:0] cfg_chan,
   input  logic [ENT_W-1:0]  cfg_entry,
   input  logic [31:0]       cfg_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [CTRL_W-1:0] in_ctrl,
   input  logic [CHAN_W-1:0] in_chan,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_chan_addr,
   output logic [3:0]        out_skt_ways,
   output logic [2:0]        out_chan_ways,
   output logic              out_miss
);

   if (ADDR_W < MIN_ADDR_W || ADDR_W > 64) begin : g_bad_addr_w
      $error("chan_addr_unilv: ADDR_W must lie in 46..64");
   end
   if (N_CTRL < 2 || N_CHAN < 2 || N_ENTRY < 2) begin : g_bad_counts
      $error("chan_addr_unilv: N_CTRL, N_CHAN and N_ENTRY must be at least 2");
   end

   typedef enum logic [2:0] {
      ST_IDLE, ST_SCAN, ST_L1, ST_L1W, ST_L2, ST_L2W, ST_DONE
   } st_e;

   st_e               st;
   logic [ADDR_W-1:0] a_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [CHAN_W-1:0] chan_q;
   logic [ENT_W-1:0]  idx_q;
   logic [ADDR_W-1:0] cur;
   logic              miss_q;
   logic [1:0]        sgc, cgc, swc, cwc;
   logic              chan_first;

   logic [31:0]       rd_base, rd_ways, rd_ofs;
   logic [ADDR_W-1:0] base_a, lim_a, ofs_a;
   logic              hit;

   cau_cfg_store #(
      .N_CTRL  (N_CTRL),
      .N_CHAN  (N_CHAN),
      .N_ENTRY (N_ENTRY),
      .CTRL_W  (CTRL_W),
      .CHAN_W  (CHAN_W),
      .ENT_W   (ENT_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && (st == ST_IDLE)),
      .wr_kind (cfg_kind),
      .wr_ctrl (cfg_ctrl),
      .wr_chan (cfg_chan),
      .wr_ent  (cfg_entry),
      .wr_data (cfg_data),
      .rd_ctrl (ctrl_q),
      .rd_chan (chan_q),
      .rd_ent  (idx_q),
      .rd_base (rd_base),
      .rd_ways (rd_ways),
      .rd_ofs  (rd_ofs)
   );

   assign base_a = ADDR_W'({rd_base[31:12], {FIELD_LSB{1'b0}}});
   assign lim_a  = ADDR_W'({rd_ways[31:12], {FIELD_LSB{1'b1}}});
   assign ofs_a  = ADDR_W'({rd_ofs[23:4],   {FIELD_LSB{1'b0}}});
   assign hit    = (a_q >= base_a) && (a_q <= lim_a);

   // Shared level remover, inputs steered by phase and removal order
   logic              lvl_start, lvl_done;
   logic [ADDR_W-1:0] lvl_res, lvl_lo;
   logic [1:0]        lvl_g;
   logic [3:0]        lvl_ways, skt_ways, chn_ways;
   logic              second;

   assign skt_ways  = 4'd1 << swc;
   assign chn_ways  = {2'b00, cwc} + 4'd1;
   assign second    = (st == ST_L2) || (st == ST_L2W);
   assign lvl_start = (st == ST_L1) || (st == ST_L2);

   always_comb begin
      if (chan_first) begin
         lvl_lo   = cur;
         lvl_g    = second ? sgc : cgc;
         lvl_ways = second ? skt_ways : chn_ways;
      end else begin
         lvl_lo   = a_q;
         lvl_g    = second ? cgc : sgc;
         lvl_ways = second ? chn_ways : skt_ways;
      end
   end

   cau_level_strip #(
      .ADDR_W (ADDR_W)
   ) u_strip (
      .clk   (clk),
      .rst_n (rst_n),
      .start (lvl_start),
      .val   (cur),
      .lo    (lvl_lo),
      .gcode (lvl_g),
      .ways  (lvl_ways),
      .done  (lvl_done),
      .res   (lvl_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         a_q        <= '0;
         ctrl_q     <= '0;
         chan_q     <= '0;
         idx_q      <= '0;
         cur        <= '0;
         miss_q     <= 1'b0;
         sgc        <= '0;
         cgc        <= '0;
         swc        <= '0;
         cwc        <= '0;
         chan_first <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (in_valid) begin
               a_q    <= in_addr;
               ctrl_q <= in_ctrl;
               chan_q <= in_chan;
               idx_q  <= '0;
               miss_q <= 1'b0;
               st     <= ST_SCAN;
            end
            ST_SCAN: begin
               if (hit) begin
                  sgc        <= rd_base[5:4];
                  cgc        <= rd_base[7:6];
                  swc        <= rd_ways[11:10];
                  cwc        <= rd_ways[9:8];
                  cur        <= a_q - ofs_a;
                  chan_first <= (rd_ways[9:8] == 2'd2) &&
                                (gran_bit(rd_base[5:4]) > gran_bit(rd_base[7:6]));
                  st         <= ST_L1;
               end else if (idx_q == ENT_W'(N_ENTRY - 1)) begin
                  miss_q <= 1'b1;
                  cur    <= '0;
                  swc    <= '0;
                  cwc    <= '0;
                  st     <= ST_DONE;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_L1:  st <= ST_L1W;
            ST_L1W: if (lvl_done) begin
               cur <= lvl_res;
               st  <= ST_L2;
            end
            ST_L2:  st <= ST_L2W;
            ST_L2W: if (lvl_done) begin
               cur <= lvl_res;
               st  <= ST_DONE;
            end
            ST_DONE: if (out_ready) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign in_ready      = (st == ST_IDLE);
   assign out_valid     = (st == ST_DONE);
   assign out_chan_addr = cur;
   assign out_miss      = miss_q;
   assign out_skt_ways  = skt_ways;
   assign out_chan_ways = chn_ways[2:0];

endmodule

// File: rtl/chan_addr_unilv_chk.sv
module chan_addr_unilv_chk #(
   parameter int unsigned ADDR_W  = 46,
   parameter int unsigned N_ENTRY = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [ADDR_W-1:0] out_chan_addr,
   input logic [3:0]        out_skt_ways,
   input logic [2:0]        out_chan_ways,
   input logic              out_miss
);

   localparam int unsigned MAX_LAT = N_ENTRY + 2 * (ADDR_W + 4) + 4;

   logic [15:0] work_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) work_cnt <= '0;
      else if (!in_ready && !out_valid) work_cnt <= work_cnt + 16'd1;
      else work_cnt <= '0;
   end

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_chan_addr) &&
         $stable(out_miss) && $stable(out_skt_ways) && $stable(out_chan_ways)));

   // R8
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   // R8
   result_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R3
   ways_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_miss) |-> ($onehot(out_skt_ways) &&
         out_chan_ways >= 3'd1 && out_chan_ways <= 3'd4));

   // R2
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_miss) |-> (out_chan_addr == '0 &&
         out_skt_ways == 4'd1 && out_chan_ways == 3'd1));

   // R1
   scan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      work_cnt <= 16'(MAX_LAT));

endmodule

bind chan_addr_unilv chan_addr_unilv_chk #(
   .ADDR_W  (ADDR_W),
   .N_ENTRY (N_ENTRY)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .in_ready      (in_ready),
   .out_valid     (out_valid),
   .out_ready     (out_ready),
   .out_chan_addr (out_chan_addr),
   .out_skt_ways  (out_skt_ways),
   .out_chan_ways (out_chan_ways),
   .out_miss      (out_miss)
);

// File: tb/chan_addr_unilv_bench.sv
module chan_addr_unilv_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 46;
   localparam logic [63:0] AMASK = (64'd1 << AW) - 64'd1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_kind = 2'd0;
   logic [0:0]    cfg_ctrl = '0;
   logic [1:0]    cfg_chan = '0;
   logic [2:0]    cfg_entry = '0;
   logic [31:0]   cfg_data = '0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [AW-1:0] in_addr = '0;
   logic [0:0]    in_ctrl = '0;
   logic [1:0]    in_chan = '0;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [AW-1:0] out_chan_addr;
   logic [3:0]    out_skt_ways;
   logic [2:0]    out_chan_ways;
   logic          out_miss;

   always #(CLK_PERIOD / 2) clk = ~clk;

   chan_addr_unilv u_chan_addr_unilv (
      .clk (clk), .rst_n (rst_n),
      .cfg_we (cfg_we), .cfg_kind (cfg_kind), .cfg_ctrl (cfg_ctrl),
      .cfg_chan (cfg_chan), .cfg_entry (cfg_entry), .cfg_data (cfg_data),
      .in_valid (in_valid), .in_ready (in_ready), .in_addr (in_addr),
      .in_ctrl (in_ctrl), .in_chan (in_chan),
      .out_valid (out_valid), .out_ready (out_ready),
      .out_chan_addr (out_chan_addr), .out_skt_ways (out_skt_ways),
      .out_chan_ways (out_chan_ways), .out_miss (out_miss)
   );

   int nchk = 0;
   int nerr = 0;
   logic [31:0] m_base [2][8];
   logic [31:0] m_ways [2][8];
   logic [31:0] m_ofs  [2][3][8];

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic int gbit(input logic [1:0] c);
      case (c)
         2'd0: return 6;
         2'd1: return 8;
         2'd2: return 12;
         default: return 30;
      endcase
   endfunction

   function automatic logic [63:0] strip(input logic [63:0] x, input int g,
                                         input int w, input logic [63:0] lo);
      return ((((x >> g) / 64'(w)) << g) | (lo & ((64'd1 << g) - 64'd1))) & AMASK;
   endfunction

   task automatic ref_dec(input logic [63:0] a, input int c, input int ch,
                          output bit miss, output logic [63:0] ca,
                          output int sw, output int cw);
      int e;
      logic [63:0] lo_b, hi_b;
      int sg, cg;
      e = -1;
      for (int i = 0; i < 8; i++) begin
         lo_b = {18'd0, m_base[c][i][31:12], 26'd0};
         hi_b = {18'd0, m_ways[c][i][31:12], 26'h3ffffff};
         if (e < 0 && a >= lo_b && a <= hi_b) e = i;
      end
      miss = (e < 0); ca = 0; sw = 1; cw = 1;
      if (!miss) begin
         sw = 1 << m_ways[c][e][11:10];
         cw = int'(m_ways[c][e][9:8]) + 1;
         sg = gbit(m_base[c][e][5:4]);
         cg = gbit(m_base[c][e][7:6]);
         ca = (a - {18'd0, m_ofs[c][ch][e][23:4], 26'd0}) & AMASK;
         if (cw == 3 && sg > cg) begin
            ca = strip(ca, cg, 3, ca);
            ca = strip(ca, sg, sw, ca);
         end else begin
            ca = strip(ca, sg, sw, a);
            ca = strip(ca, cg, cw, a);
         end
      end
   endtask

   task automatic cfg_wr(input int kind, input int c, input int ch, input int e,
                         input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_ctrl = 1'(c);
      cfg_chan = 2'(ch); cfg_entry = 3'(e); cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (kind == 0) m_base[c][e] = d;
      if (kind == 1) m_ways[c][e] = d;
      if (kind == 2) m_ofs[c][ch][e] = d;
   endtask

   // Issues one request, optionally a write mid-flight and an output stall
   task automatic dec(input logic [63:0] a, input int c, input int ch,
                      input int stall, input bit mid_wr, input string tag,
                      output int got_cw);
      bit e_miss; logic [63:0] e_ca; int e_sw, e_cw;
      logic [AW-1:0] hold;
      ref_dec(a, c, ch, e_miss, e_ca, e_sw, e_cw);
      @(negedge clk);
      in_valid = 1'b1; in_addr = a[AW-1:0]; in_ctrl = 1'(c); in_chan = 2'(ch);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(!in_ready, "R8", "in_ready after accept", 64'(in_ready), 0);
      if (mid_wr) begin
         cfg_we = 1'b1; cfg_kind = 2'd0; cfg_ctrl = 1'(c); cfg_entry = 3'd0;
         cfg_data = 32'hFFFF_F000;
         @(negedge clk);
         cfg_we = 1'b0;
      end
      while (!out_valid) @(negedge clk);
      hold = out_chan_addr;
      for (int s = 0; s < stall; s++) begin
         @(negedge clk);
         check(out_valid && out_chan_addr == hold, "R8", "held result",
               64'(out_chan_addr), 64'(hold));
      end
      check(out_miss == e_miss, e_miss ? "R2" : "R1", "miss flag",
            64'(out_miss), 64'(e_miss));
      check(64'(out_chan_addr) == e_ca, tag, "channel address",
            64'(out_chan_addr), e_ca);
      check(int'(out_skt_ways) == e_sw, "R3", "socket ways",
            64'(out_skt_ways), 64'(e_sw));
      check(int'(out_chan_ways) == e_cw, "R3", "channel ways",
            64'(out_chan_ways), 64'(e_cw));
      got_cw = int'(out_chan_ways);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic rand_cfg(output int top_unit);
      int cur, len;
      top_unit = 0;
      for (int c = 0; c < 2; c++) begin
         cur = 0;
         for (int e = 0; e < 8; e++) begin
            len = 1 + int'($urandom % 3);
            cfg_wr(0, c, 0, e, {20'(cur), 4'd0, 2'($urandom), 2'($urandom), 4'd0});
            cfg_wr(1, c, 0, e, {20'(cur + len - 1), 2'($urandom), 2'($urandom), 8'd0});
            for (int h = 0; h < 3; h++)
               cfg_wr(2, c, h, e, {8'd0, 20'($urandom % (cur + 1)), 4'd0});
            cur += len;
            if (e == 3) cur += 1;
         end
         if (cur > top_unit) top_unit = cur;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL R8 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      int cw_got, top;
      logic [63:0] a;
      void'($urandom(32'd4242));
      for (int c = 0; c < 2; c++)
         for (int e = 0; e < 8; e++) begin
            m_base[c][e] = 0; m_ways[c][e] = 0;
            for (int h = 0; h < 3; h++) m_ofs[c][h][e] = 0;
         end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check(in_ready == 1'b1, "R10", "in_ready", 64'(in_ready), 1);
      check(out_valid == 1'b0, "R10", "out_valid", 64'(out_valid), 0);
      dec(64'h123_4567, 0, 1, 0, 0, "R10", cw_got);
      dec(64'h800_0000, 1, 2, 0, 0, "R2", cw_got);

      // R5 offset subtraction with one-way levels
      cfg_wr(1, 0, 0, 0, {20'd9, 12'd0});
      cfg_wr(2, 0, 1, 0, {8'd0, 20'd2, 4'd0});
      dec({18'd0, 20'd5, 26'h155_1234}, 0, 1, 0, 0, "R5", cw_got);

      // R1 first-match priority with overlapping windows
      cfg_wr(0, 0, 0, 0, 32'd0);
      cfg_wr(1, 0, 0, 0, {20'd5, 2'd0, 2'd1, 8'd0});
      cfg_wr(0, 0, 0, 1, 32'd0);
      cfg_wr(1, 0, 0, 1, {20'd10, 2'd0, 2'd3, 8'd0});
      dec({18'd0, 20'd3, 26'h0ab_cdef}, 0, 0, 0, 0, "R1", cw_got);
      check(cw_got == 2, "R1", "window 0 chosen", 64'(cw_got), 2);

      // R6 channel-first removal: 3-way channel at bit 6, socket at bit 30
      cfg_wr(0, 1, 0, 0, {20'd0, 4'd0, 2'd0, 2'd3, 4'd0});
      cfg_wr(1, 1, 0, 0, {20'd63, 2'd1, 2'd2, 8'd0});
      dec(64'hDEAD_BEEF, 1, 2, 0, 0, "R6", cw_got);
      dec(64'h7654_3217, 1, 0, 2, 0, "R6", cw_got);

      // R7 socket-first removal: 3-way channel at bit 12, socket at bit 6
      cfg_wr(0, 1, 0, 0, {20'd0, 4'd0, 2'd2, 2'd0, 4'd0});
      cfg_wr(1, 1, 0, 0, {20'd63, 2'd2, 2'd2, 8'd0});
      dec(64'h9876_5432, 1, 1, 0, 0, "R7", cw_got);

      // R9 write during a decode leaves the window unchanged
      dec(64'h1234_5678, 1, 1, 0, 1, "R9", cw_got);
      dec(64'h1234_5678, 1, 1, 0, 0, "R9", cw_got);

      // R11 kind 3 writes nothing
      @(negedge clk);
      cfg_we = 1'b1; cfg_kind = 2'd3; cfg_ctrl = 1'd1; cfg_entry = 3'd0;
      cfg_data = 32'hFFFF_FFFF;
      @(negedge clk);
      cfg_we = 1'b0;
      dec(64'h0ABC_DEF1, 1, 2, 3, 0, "R11", cw_got);

      // R4 random windows, granularities, ways and offsets
      for (int r = 0; r < 3; r++) begin
         rand_cfg(top);
         for (int q = 0; q < 40; q++) begin
            a = {18'd0, 20'($urandom % (top + 3)), 26'($urandom)};
            dec(a, int'($urandom % 2), int'($urandom % 3),
                int'($urandom % 3), 0, "R4", cw_got);
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule